// File: doc/BRIEF.md
# Multi-Port Gated Write Register

A single storage word fed by several independent write ports. Each port is a strobe bit paired with a data word. On every rising clock edge the register computes its next value as an AND-OR merge over the ports. Every port whose strobe is high contributes its data. The held word is fed back whenever no strobe is high. Because there is no encoded select and no priority, the usual case of one port writing alone costs one gate level per port plus the OR reduction.

The block also brings out a combined strobe. It is high in the same cycle that any port writes, so neighbouring merge or completion logic can see write activity without decoding the strobe vector itself. The port count, the data width and the shape of the OR reduction are parameters. The stored word starts at zero after a synchronous reset and has no other initialization.

Top module: `mpr_multiport_reg`

## Requirements
- R1: When exactly one strobe `wr_stb[i]` is high at a rising edge, `q` equals `wr_data[i]` after that edge.
- R2: When no strobe is high at a rising edge, `q` keeps its previous value after that edge.
- R3: When several strobes are high at a rising edge, `q` becomes the bitwise OR of the data words of exactly those ports.
- R4: `any_stb` is high in the same cycle as any bit of `wr_stb` and low otherwise, with no clock edge in between.
- R5: A high `rst` at a rising edge clears `q` to all zeros after that edge, whatever the strobes and data are.
- R6: After reset is released, `q` reads zero until the first write.
- R7: The data word of a port whose strobe is low has no effect on `q`, whether other ports write or not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | NUM_PORTS | Write strobe per port, bit i belongs to port i |
| wr_data | input | NUM_PORTS x DATA_W | Data word per port, packed as [port][bit] |
| q | output | DATA_W | Stored word |
| any_stb | output | 1 | High while any write strobe is high |

## Verification
A write from one port and a write from another port can fall in the same clock cycle. The same holds for reset and a write. The bench provokes overlapping writes both directly, with two-port and all-port strobes carrying disjoint and overlapping bit patterns, and at random, with strobe vectors weighted toward several bits set. It judges the result against an OR of only the strobed ports' data. Reset is also asserted together with full strobes and all-ones data, and the register must read zero after that edge.

// File: rtl/mpr_pkg.sv
package mpr_pkg;

   typedef enum logic [0:0] {
      MERGE_FLAT = 1'b0,
      MERGE_TREE = 1'b1
   } merge_style_e;

   function automatic int unsigned pad_pow2(input int unsigned n);
      int unsigned p;
      p = 1;
      while (p < n) p = p << 1;
      return p;
   endfunction

endpackage

// File: rtl/mpr_gate_terms.sv
module mpr_gate_terms #(
   parameter int unsigned NUM_PORTS = 3,
   parameter int unsigned DATA_W    = 8,
   localparam int unsigned NUM_TERMS = NUM_PORTS + 1
) (
   input  logic [NUM_PORTS-1:0]             stb,
   input  logic [NUM_PORTS-1:0][DATA_W-1:0] data,
   input  logic [DATA_W-1:0]                held,
   output logic [NUM_TERMS-1:0][DATA_W-1:0] terms,
   output logic                             any
);

   logic any_w;

   always_comb begin
      any_w = 1'b0;
      for (int i = 0; i < int'(NUM_PORTS); i++) any_w = any_w | stb[i];
   end

   for (genvar g = 0; g < int'(NUM_PORTS); g++) begin : g_port
      assign terms[g] = data[g] & {DATA_W{stb[g]}};
   end

   assign terms[NUM_PORTS] = held & {DATA_W{~any_w}};
   assign any = any_w;

endmodule

// File: rtl/mpr_or_reduce.sv
module mpr_or_reduce
   import mpr_pkg::*;
#(
   parameter int unsigned  NUM_IN = 4,
   parameter int unsigned  DATA_W = 8,
   parameter merge_style_e STYLE  = MERGE_TREE,
   localparam int unsigned PAD    = pad_pow2(NUM_IN),
   localparam int unsigned LEVELS = $clog2(PAD)
) (
   input  logic [NUM_IN-1:0][DATA_W-1:0] din,
   output logic [DATA_W-1:0]             dout
);

   if (STYLE == MERGE_FLAT) begin : g_flat
      always_comb begin
         dout = '0;
         for (int i = 0; i < int'(NUM_IN); i++) dout = dout | din[i];
      end
   end else begin : g_tree
      for (genvar l = 0; l <= int'(LEVELS); l++) begin : lvl
         logic [(PAD>>l)-1:0][DATA_W-1:0] v;
         if (l == 0) begin : g_leaf
            for (genvar j = 0; j < int'(PAD); j++) begin : g_j
               if (j < int'(NUM_IN)) begin : g_real
                  assign v[j] = din[j];
               end else begin : g_pad
                  assign v[j] = '0;
               end
            end
         end else begin : g_node
            for (genvar j = 0; j < int'(PAD >> l); j++) begin : g_j
               assign v[j] = lvl[l-1].v[2*j] | lvl[l-1].v[2*j+1];
            end
         end
      end
      assign dout = lvl[LEVELS].v[0];
   end

endmodule

// File: rtl/mpr_state_reg.sv
module mpr_state_reg #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] nxt,
   output logic [DATA_W-1:0] q
);

   logic [DATA_W-1:0] q_r;

   always_ff @(posedge clk) begin
      if (rst) q_r <= '0;
      else     q_r <= nxt;
   end

   assign q = q_r;

   // R5: reset wins over any computed next value
   p_reset_clears_r5: assert property (@(posedge clk) rst |=> (q == '0))
      else $error("reset did not clear stored word");

endmodule

// File: rtl/mpr_multiport_reg.sv
module mpr_multiport_reg
   import mpr_pkg::*;
#(
   parameter int unsigned  NUM_PORTS = 3,
   parameter int unsigned  DATA_W    = 8,
   parameter merge_style_e MERGE     = MERGE_TREE
) (
   input  logic                             clk,
   input  logic                             rst,
   input  logic [NUM_PORTS-1:0]             wr_stb,
   input  logic [NUM_PORTS-1:0][DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0]                q,
   output logic                             any_stb
);

   localparam int unsigned NUM_TERMS = NUM_PORTS + 1;

   if (NUM_PORTS < 1) begin : g_chk_ports
      $error("NUM_PORTS must be at least 1");
   end
   if (DATA_W < 1) begin : g_chk_width
      $error("DATA_W must be at least 1");
   end

   logic [NUM_TERMS-1:0][DATA_W-1:0] terms;
   logic [DATA_W-1:0]                merged;
   logic                             any_w;
   logic [DATA_W-1:0]                q_w;

   mpr_gate_terms #(
      .NUM_PORTS(NUM_PORTS),
      .DATA_W   (DATA_W)
   ) u_terms (
      .stb  (wr_stb),
      .data (wr_data),
      .held (q_w),
      .terms(terms),
      .any  (any_w)
   );

   mpr_or_reduce #(
      .NUM_IN(NUM_TERMS),
      .DATA_W(DATA_W),
      .STYLE (MERGE)
   ) u_merge (
      .din (terms),
      .dout(merged)
   );

   mpr_state_reg #(
      .DATA_W(DATA_W)
   ) u_state (
      .clk(clk),
      .rst(rst),
      .nxt(merged),
      .q  (q_w)
   );

   assign q       = q_w;
   assign any_stb = any_w;

   // R1: a lone strobe loads its own port's word
   for (genvar p = 0; p < int'(NUM_PORTS); p++) begin : g_chk_port
      p_single_load_r1: assert property (@(posedge clk) disable iff (rst)
         (wr_stb == (NUM_PORTS'(1) << p)) |=> (q == $past(wr_data[p])))
         else $error("single strobe load wrong on port %0d", p);
   end

   // R2: quiet cycle keeps the word
   p_hold_r2: assert property (@(posedge clk) disable iff (rst)
      (wr_stb == '0) |=> $stable(q))
      else $error("word changed with no strobe");

   // R4: combined strobe low means merge output is the held word
   p_idle_merge_r4: assert property (@(posedge clk) disable iff (rst)
      !any_stb |-> (merged == q))
      else $error("merge not transparent while idle");

   // R4: combined strobe high implies at least one input strobe
   p_any_has_src_r4: assert property (@(posedge clk) disable iff (rst)
      any_stb |-> ($countones(wr_stb) > 0))
      else $error("combined strobe without a source");

endmodule

// File: tb/tb_mpr_multiport_reg.sv
module tb_mpr_multiport_reg;
   import mpr_pkg::*;

   localparam int unsigned N = 3;
   localparam int unsigned W = 8;

   logic                   clk = 1'b0;
   logic                   rst = 1'b1;
   logic [N-1:0]           wr_stb = '0;
   logic [N-1:0][W-1:0]    wr_data = '0;
   logic [W-1:0]           q;
   logic                   any_stb;

   int checks = 0;
   int errors = 0;
   logic [W-1:0] exp_q = '0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   mpr_multiport_reg #(.NUM_PORTS(N), .DATA_W(W), .MERGE(MERGE_TREE)) dut (
      .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_data(wr_data),
      .q(q), .any_stb(any_stb)
   );

   function automatic logic [W-1:0] model_next(input logic r, input logic [N-1:0] s,
                                                input logic [N-1:0][W-1:0] d,
                                                input logic [W-1:0] cur);
      logic [W-1:0] acc;
      if (r) return '0;
      if (s == '0) return cur;
      acc = '0;
      for (int i = 0; i < int'(N); i++) if (s[i]) acc = acc | d[i];
      return acc;
   endfunction

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, expv);
      end
   endtask

   // drive at negedge, check combined strobe, then check word after the edge
   task automatic cycle(input string req, input logic r, input logic [N-1:0] s,
                        input logic [N-1:0][W-1:0] d);
      @(negedge clk);
      rst = r; wr_stb = s; wr_data = d;
      #1;
      check("R4 any_stb", W'(any_stb), W'(|s));
      exp_q = model_next(r, s, d, exp_q);
      @(posedge clk);
      #1;
      check(req, q, exp_q);
   endtask

   initial begin
      #4_000_000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [N-1:0][W-1:0] d;
      void'($urandom(32'd1234));
      // R6: reset state
      repeat (2) @(posedge clk);
      #1;
      exp_q = '0;
      check("R6 reset value", q, '0);
      cycle("R6 idle after reset", 1'b0, '0, {8'hFF, 8'hFF, 8'hFF});
      // R1: each port alone
      d = {8'h3C, 8'hA5, 8'h5A};
      cycle("R1 port0", 1'b0, 3'b001, d);
      cycle("R1 port1", 1'b0, 3'b010, d);
      cycle("R1 port2", 1'b0, 3'b100, d);
      // R2: hold with changing data
      cycle("R2 hold", 1'b0, 3'b000, {8'h00, 8'hFF, 8'h11});
      cycle("R2 hold again", 1'b0, 3'b000, {8'hEE, 8'h01, 8'h80});
      // R3: overlap, disjoint and overlapping bits
      cycle("R3 two ports disjoint", 1'b0, 3'b011, {8'hFF, 8'hF0, 8'h0F});
      cycle("R3 all ports", 1'b0, 3'b111, {8'h81, 8'h18, 8'h42});
      // R7: unstrobed port data ignored
      cycle("R7 ignored data", 1'b0, 3'b001, {8'hFF, 8'hFF, 8'h00});
      cycle("R7 ignored during hold", 1'b0, 3'b000, {8'hAA, 8'h55, 8'hFF});
      // R5: reset together with full writes
      cycle("R5 reset beats writes", 1'b1, 3'b111, {8'hFF, 8'hFF, 8'hFF});
      cycle("R1 after reset", 1'b0, 3'b100, {8'h77, 8'h00, 8'h00});
      // random mix
      for (int k = 0; k < 400; k++) begin
         logic [N-1:0] s;
         logic r;
         for (int i = 0; i < int'(N); i++) d[i] = W'($urandom);
         s = N'($urandom);
         if (($urandom % 4) == 0) s = s | N'($urandom);
         r = (($urandom % 40) == 0);
         cycle("R3 random", r, s, d);
      end
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule